// File: doc/BRIEF.md
# Grouped Lookahead Adder-Subtractor

This is a purely combinational two's-complement adder-subtractor of width `WIDTH` bits, where `WIDTH` must be a multiple of four. The same datapath serves both signed and unsigned operands. A mode input picks addition or subtraction. In add mode an external carry-in joins the sum. In subtract mode the second operand is inverted bit by bit and the carry-in is forced to one, so the block returns `opa - opb` and the external carry-in is ignored.

Carries do not ripple. Every bit forms a generate term and a propagate term. Each four-bit group folds these into a group generate and a group propagate. The carry into every group is then a flat sum of products over the group terms of all lower groups and the initial carry. Inside a group, each bit's carry is a flat expression over that group's incoming carry and its own bit terms.

The block also reports a carry-out and a signed overflow flag. The carry-out is taken from the top group. The overflow flag is the carry into the top bit XOR the carry leaving it.

Top module: `cla_addsub`

## Requirements
- R1: With `sub_en`=0, `{carry_out, result}` equals `opa + opb + carry_in`, evaluated as an unsigned value of WIDTH+1 bits.
- R2: With `sub_en`=1, `result` equals `(opa - opb) mod 2^WIDTH` for both values of `carry_in`. The external carry-in has no effect in this mode.
- R3: With `sub_en`=0, `ovf` is 1 exactly when the signed sum of `opa`, `opb` and `carry_in` lies outside the range -2^(WIDTH-1) to 2^(WIDTH-1)-1.
- R4: With `sub_en`=1, `ovf` is 1 exactly when the signed difference `opa - opb` lies outside that same range.
- R5: With `sub_en`=1, `carry_out` is 1 exactly when `opa >= opb` as unsigned numbers, meaning no borrow.
- R6: A carry entering bit 0 travels through every group. With `opa` all ones, `opb`=0, `sub_en`=0 and `carry_in`=1, the outputs are `result`=0 and `carry_out`=1.
- R7: A carry produced in one group reaches the next group. For example, `opa`=0x000F plus `opb`=0x0001 gives 0x0010. With all inputs at zero, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa | input | WIDTH | First operand (minuend in subtract mode) |
| opb | input | WIDTH | Second operand (subtrahend in subtract mode) |
| sub_en | input | 1 | 1 selects subtraction, 0 selects addition |
| carry_in | input | 1 | Carry into bit 0 in add mode; ignored when subtracting |
| result | output | WIDTH | Sum or difference, modulo 2^WIDTH |
| carry_out | output | 1 | Carry leaving the top group; in subtract mode, 1 means no borrow |
| ovf | output | 1 | Signed overflow of the result |

## Verification
The bench targets the carry chains that cross group boundaries, including a carry that must pass through all groups from bit 0. A design that drops a group propagate term would return a result that is off by a multiple of 16 for these inputs.

Subtraction is checked with `carry_in` at both values. An implementation that still adds the external carry would produce a difference that is one too large.

The operand values 0, all-ones, the most positive number and the most negative number are paired in both modes. Deriving overflow from the wrong carry would flag sums such as max+1 incorrectly. Inverting the borrow would break the `carry_out` result for equal operands.

Random operands are then compared against a reference that is one bit wider than the result.

// File: rtl/cla_addsub.sv
module cla_addsub #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  input  logic             sub_en,
  input  logic             carry_in,
  output logic [WIDTH-1:0] result,
  output logic             carry_out,
  output logic             ovf
);
  localparam int NGRP = WIDTH / 4;

  logic [WIDTH-1:0] bx, gen, prop, cbit;
  logic [NGRP-1:0]  ggen, gprop;
  logic [NGRP:0]    cgrp;
  logic             c0;

  initial begin
    if (WIDTH % 4 != 0 || WIDTH < 4) $error("WIDTH must be a positive multiple of 4");
  end

  assign bx   = opb ^ {WIDTH{sub_en}};
  assign c0   = sub_en | carry_in;
  assign gen  = opa & bx;
  assign prop = opa ^ bx;

  always_comb begin
    logic term;
    for (int k = 0; k < NGRP; k++) begin
      ggen[k]  = 1'b0;
      gprop[k] = &prop[4*k +: 4];
      for (int i = 0; i < 4; i++) begin
        term = gen[4*k+i];
        for (int j = i + 1; j < 4; j++) term = term & prop[4*k+j];
        ggen[k] = ggen[k] | term;
      end
    end
  end

  always_comb begin
    logic acc, term;
    cgrp[0] = c0;
    for (int k = 0; k < NGRP; k++) begin
      acc = c0;
      for (int m = 0; m <= k; m++) acc = acc & gprop[m];
      for (int j = 0; j <= k; j++) begin
        term = ggen[j];
        for (int m = j + 1; m <= k; m++) term = term & gprop[m];
        acc = acc | term;
      end
      cgrp[k+1] = acc;
    end
  end

  always_comb begin
    logic acc, term;
    for (int k = 0; k < NGRP; k++) begin
      for (int i = 0; i < 4; i++) begin
        acc = cgrp[k];
        for (int m = 0; m < i; m++) acc = acc & prop[4*k+m];
        for (int j = 0; j < i; j++) begin
          term = gen[4*k+j];
          for (int m = j + 1; m < i; m++) term = term & prop[4*k+m];
          acc = acc | term;
        end
        cbit[4*k+i] = acc;
      end
    end
  end

  assign result    = prop ^ cbit;
  assign carry_out = cgrp[NGRP];
  assign ovf       = cbit[WIDTH-1] ^ cgrp[NGRP];
endmodule

module cla_addsub_chk #(
  parameter int WIDTH = 16
) (
  input logic [WIDTH-1:0] opa,
  input logic [WIDTH-1:0] opb,
  input logic             sub_en,
  input logic             carry_in,
  input logic [WIDTH-1:0] result,
  input logic             carry_out,
  input logic             ovf
);
  logic [WIDTH:0] wide_add, wide_sub;
  logic           sgn_a, sgn_b, sgn_r;

  assign wide_add = {1'b0, opa} + {1'b0, opb} + {{WIDTH{1'b0}}, carry_in};
  assign wide_sub = {1'b0, opa} - {1'b0, opb};
  assign sgn_a = opa[WIDTH-1];
  assign sgn_b = opb[WIDTH-1];
  assign sgn_r = result[WIDTH-1];

  always_comb begin
    if (!sub_en) AST_ADD_SUM: assert ({carry_out, result} == wide_add); // R1
    if (sub_en) AST_SUB_DIFF: assert (result == wide_sub[WIDTH-1:0]); // R2
    if (!sub_en) AST_ADD_OVF: assert (ovf == ((sgn_a == sgn_b) && (sgn_r != sgn_a))); // R3
    if (sub_en) AST_SUB_OVF: assert (ovf == ((sgn_a != sgn_b) && (sgn_r != sgn_a))); // R4
    if (sub_en) AST_NO_BORROW: assert (carry_out == (opa >= opb)); // R5
  end
endmodule

bind cla_addsub cla_addsub_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/cla_addsub_test.sv
module cla_addsub_test;
  localparam int W = 16;
  localparam logic [W-1:0] ONES = {W{1'b1}};
  localparam logic [W-1:0] MAXP = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MAXN = {1'b1, {(W-1){1'b0}}};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [W-1:0] opa, opb, result;
  logic sub_en, carry_in, carry_out, ovf;
  int n_chk = 0, n_fail = 0;

  cla_addsub #(.WIDTH(W)) uut (.opa(opa), .opb(opb), .sub_en(sub_en), .carry_in(carry_in),
    .result(result), .carry_out(carry_out), .ovf(ovf));

  task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b, input logic s, input logic ci);
    @(posedge clk);
    opa = a; opb = b; sub_en = s; carry_in = ci;
    @(negedge clk);
  endtask

  task automatic expect_val(input string req, input string what, input logic [W:0] act, input logic [W:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: a=%h b=%h sub=%b cin=%b actual=%h expected=%h",
               req, what, opa, opb, sub_en, carry_in, act, exp);
    end
  endtask

  task automatic check_ref(input logic [W-1:0] a, input logic [W-1:0] b, input logic s, input logic ci);
    logic [W:0] ref_u;
    logic signed [W:0] ref_s;
    logic ref_ov;
    apply(a, b, s, ci);
    if (!s) begin
      ref_u = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, ci};
      ref_s = $signed({a[W-1], a}) + $signed({b[W-1], b}) + $signed({{W{1'b0}}, ci});
    end else begin
      ref_u = {1'b0, a} + {1'b0, ~b} + 1'b1;
      ref_s = $signed({a[W-1], a}) - $signed({b[W-1], b});
    end
    ref_ov = ref_s[W] ^ ref_s[W-1];
    expect_val(s ? "R2" : "R1", "result", {1'b0, result}, {1'b0, ref_u[W-1:0]});
    if (s) expect_val("R5", "carry_out", {{W{1'b0}}, carry_out}, {{W{1'b0}}, (a >= b)});
    else   expect_val("R1", "carry_out", {{W{1'b0}}, carry_out}, {{W{1'b0}}, ref_u[W]});
    expect_val(s ? "R4" : "R3", "ovf", {{W{1'b0}}, ovf}, {{W{1'b0}}, ref_ov});
  endtask

  task automatic t_reset_state;
    apply('0, '0, 1'b0, 1'b0);
    expect_val("R7", "idle result", {carry_out, result}, '0);
    expect_val("R7", "idle ovf", {{W{1'b0}}, ovf}, '0);
  endtask

  task automatic t_group_carry;
    apply(16'h000F, 16'h0001, 1'b0, 1'b0);
    expect_val("R7", "group hop", {carry_out, result}, 17'h00010);
    apply(16'h00FF, 16'h0000, 1'b0, 1'b1);
    expect_val("R7", "two-group hop", {carry_out, result}, 17'h00100);
    apply(ONES, '0, 1'b0, 1'b1);
    expect_val("R6", "full chain", {carry_out, result}, 17'h10000);
    check_ref(16'h0FF0, 16'h0010, 1'b0, 1'b0);
  endtask

  task automatic t_sub_cin_ignored;
    for (int ci = 0; ci < 2; ci++) begin
      apply(16'h1234, 16'h0235, 1'b1, ci[0]);
      expect_val("R2", "diff cin ignored", {carry_out, result}, 17'h10FFF);
      apply(16'h0005, 16'h0007, 1'b1, ci[0]);
      expect_val("R2", "negative diff", {carry_out, result}, 17'h0FFFE);
    end
  endtask

  task automatic t_boundaries;
    logic [W-1:0] vals [4];
    vals[0] = '0; vals[1] = ONES; vals[2] = MAXP; vals[3] = MAXN;
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 4; j++)
        for (int m = 0; m < 3; m++)
          check_ref(vals[i], vals[j], m == 2, m == 1);
    apply(MAXP, 16'h0001, 1'b0, 1'b0);
    expect_val("R3", "max+1 overflow", {{W{1'b0}}, ovf}, 17'h1);
    apply(MAXN, 16'h0001, 1'b1, 1'b0);
    expect_val("R4", "min-1 overflow", {{W{1'b0}}, ovf}, 17'h1);
    apply(16'h4321, 16'h4321, 1'b1, 1'b0);
    expect_val("R5", "equal no borrow", {{W{1'b0}}, carry_out}, 17'h1);
  endtask

  task automatic t_random;
    for (int n = 0; n < 400; n++)
      check_ref(W'($urandom), W'($urandom), n[0], n[1]);
  endtask

  initial begin
    opa = '0; opb = '0; sub_en = 1'b0; carry_in = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_group_carry();
    t_sub_cin_ignored();
    t_boundaries();
    t_random();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule